// File: doc/BRIEF.md
# Store Queue with Read Forwarding

This block sits between a write-through data cache and a slower memory port. Stores from the cache are accepted into a small circular queue and sent to memory one at a time, oldest first. The cache keeps running while the queue absorbs bursts of stores. It waits only when every slot is occupied.

When the cache misses on a read, the read address is compared with every occupied slot in the same cycle. If a slot matches, the newest matching store supplies the data, and memory is not touched. If nothing matches, the read takes the memory port ahead of every store still waiting. Draining stops until the read data returns.

A read miss may also carry a dirty victim line. The victim is placed in the queue in the same cycle the read is accepted. This means the memory read is issued at once, and the victim is written back later behind the older stores. The queue depth must be a power of two, at least 2.

Top module: `wbuf_bypass`

## Requirements
- R1: A store is taken on a cycle where `st_valid` and `st_ready` are both high. The queue holds DEPTH stores (4 by default), and `st_ready` stays low while all of them are occupied.
- R2: Queued stores leave through the memory port in the order they were accepted, one per cycle in which `mem_req_valid` and `mem_req_ready` are both high. Each write is marked by `mem_req_write` = 1, and its address and data are exactly those of the store.
- R3: If a read address matches one or more queued entries when the read is accepted, `rsp_valid` rises one cycle later. `rsp_data` carries the data of the most recently queued matching entry, and no memory read is requested for that access.
- R4: If the read address matches no entry, a memory read (`mem_req_write` = 0, `mem_req_addr` = read address) is issued before any still-queued store. No write is accepted by memory until the read response has returned.
- R5: For a read sent to memory, `rsp_valid` rises one cycle after `mem_rsp_valid`, and `rsp_data` equals the `mem_rsp_data` sampled with it.
- R6: A read accepted with `rd_wb_valid` high enqueues the victim (`rd_wb_addr`, `rd_wb_data`) in that same cycle, behind all earlier stores. On a miss, the memory read request is presented in the very next cycle.
- R7: `empty` is high exactly when no entry is held, and `full` is high exactly when DEPTH entries are held. After reset `empty` = 1 and `full` = 0.
- R8: Only one read is handled at a time. `rd_ready` is low from the acceptance of a read miss until its response, and also while a victim is offered but the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered by the cache |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| rd_valid | input | 1 | Read miss offered |
| rd_ready | output | 1 | Read miss can be taken this cycle |
| rd_addr | input | AW | Read miss word address |
| rd_wb_valid | input | 1 | A dirty victim accompanies the read |
| rd_wb_addr | input | AW | Victim address |
| rd_wb_data | input | DW | Victim data |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_data | output | DW | Read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Memory request address |
| mem_req_data | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DW | Memory read data |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entry occupied |

## Verification
The bench builds the block with DEPTH = 4, AW = 8 and DW = 16. Four slots fill after only a few stores, so the full-queue stall and reads that hit a full queue are easy to reach. The narrow address field lets stores to the same address sit in the queue together, which tests youngest-match selection. Holding memory ready low keeps every store parked, so hits, a stalled miss, and the ordering of a read ahead of parked writes can each be set up on demand.

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_wb_valid,
  input  logic [AW-1:0] rd_wb_addr,
  input  logic [DW-1:0] rd_wb_data,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_data,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;

  state_t        state;
  logic [AW-1:0] e_addr [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;
  logic [AW-1:0] rd_addr_q;
  logic          rd_fire, st_fire, wb_push, push, pop, drain;
  logic          fwd_hit;
  logic [DW-1:0] fwd_data;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign rd_ready = (state == S_IDLE) && !(rd_wb_valid && full);
  assign rd_fire  = rd_valid && rd_ready;
  assign wb_push  = rd_fire && rd_wb_valid;
  assign st_ready = !full && !wb_push;
  assign st_fire  = st_valid && st_ready;
  assign push     = st_fire || wb_push;
  assign drain    = (state == S_IDLE) && !empty && !rd_fire;
  assign pop      = drain && mem_req_ready;

  assign mem_req_valid = drain || (state == S_REQ);
  assign mem_req_write = (state == S_IDLE);
  assign mem_req_addr  = (state == S_REQ) ? rd_addr_q : e_addr[head];
  assign mem_req_data  = e_data[head];

  always_comb begin
    logic [PW-1:0] idx;
    fwd_hit  = 1'b0;
    fwd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head + PW'(i);
      if (CW'(i) < count && e_addr[idx] == rd_addr) begin
        fwd_hit  = 1'b1;
        fwd_data = e_data[idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      e_addr[tail] <= wb_push ? rd_wb_addr : st_addr;
      e_data[tail] <= wb_push ? rd_wb_data : st_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      state     <= S_IDLE;
      rd_addr_q <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      count     <= count + CW'(push) - CW'(pop);
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (rd_fire) begin
          if (fwd_hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= fwd_data;
          end else begin
            rd_addr_q <= rd_addr;
            state     <= S_REQ;
          end
        end
        S_REQ:  if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          rsp_data  <= mem_rsp_data;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_full_stalls_R1: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !st_ready);
  assert_read_owns_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> !(mem_req_valid && mem_req_write));
  assert_hit_served_locally_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && fwd_hit) |=> (rsp_valid && state == S_IDLE));
  assert_miss_issued_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !fwd_hit) |=> (mem_req_valid && !mem_req_write && mem_req_addr == $past(rd_addr)));
  assert_rsp_from_memory_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && mem_rsp_valid) |=> (rsp_valid && rsp_data == $past(mem_rsp_data)));
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  assert_one_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> !rd_ready);
endmodule

// File: tb/wbuf_bypass_tb.sv
`timescale 1ns/1ps
module wbuf_bypass_tb;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic st_valid = 0, rd_valid = 0, rd_wb_valid = 0;
  logic [AW-1:0] st_addr = '0, rd_addr = '0, rd_wb_addr = '0;
  logic [DW-1:0] st_data = '0, rd_wb_data = '0;
  logic st_ready, rd_ready, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic mem_req_valid, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_data;
  logic mem_rdy = 1;
  logic mem_rsp_valid = 0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic full, empty;

  always #2 clk = ~clk;

  wbuf_bypass #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_wb_valid(rd_wb_valid), .rd_wb_addr(rd_wb_addr), .rd_wb_data(rd_wb_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_rdy), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .full(full), .empty(empty));

  typedef struct packed {logic [AW-1:0] a; logic [DW-1:0] d;} wr_t;

  int checks = 0, fails = 0, cyc = 0;
  int rd_req_cnt = 0, first_rd_req_cyc = -1, wr_during_read = 0, rsp_cyc = 0;
  bit mem_busy = 0;
  wr_t exp_wr[$];
  logic [DW-1:0] exp_rsp[$];
  bit op_log[$];
  logic [DW-1:0] mem[int];
  logic [DW-1:0] shadow[int];

  function automatic logic [DW-1:0] ival(int a);
    return DW'(a * 37 + 5);
  endfunction
  function automatic logic [DW-1:0] mem_val(int a);
    return mem.exists(a) ? mem[a] : ival(a);
  endfunction
  function automatic logic [DW-1:0] sh_val(int a);
    return shadow.exists(a) ? shadow[a] : ival(a);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory-side monitor: scoreboard for drained writes (R2), read tracking (R4)
  always @(negedge clk) begin
    if (rst_n && mem_req_valid && !mem_req_write && first_rd_req_cyc < 0)
      first_rd_req_cyc = cyc;
    if (rst_n && mem_req_valid && mem_rdy) begin
      if (mem_req_write) begin
        wr_t e;
        op_log.push_back(1'b1);
        if (mem_busy) wr_during_read++;
        mem[int'(mem_req_addr)] = mem_req_data;
        if (exp_wr.size() == 0)
          chk(0, "R2", "unexpected write", longint'(mem_req_addr), 0);
        else begin
          e = exp_wr.pop_front();
          chk(mem_req_addr == e.a && mem_req_data == e.d, "R2", "drained write {addr,data}",
              longint'({mem_req_addr, mem_req_data}), longint'({e.a, e.d}));
        end
      end else begin
        op_log.push_back(1'b0);
        rd_req_cnt++;
        mem_busy = 1;
      end
    end
  end

  // memory read responder: data two cycles after the request is taken
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid && mem_rdy && !mem_req_write) begin
        automatic int a = int'(mem_req_addr);
        @(posedge clk);
        @(posedge clk);
        #1 mem_rsp_valid = 1; mem_rsp_data = mem_val(a);
        @(posedge clk);
        #1 mem_rsp_valid = 0; mem_busy = 0;
      end
    end
  end

  // response monitor (R3, R5)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      logic [DW-1:0] e;
      rsp_cyc = cyc;
      if (exp_rsp.size() == 0)
        chk(0, "R3", "unexpected response", longint'(rsp_data), 0);
      else begin
        e = exp_rsp.pop_front();
        chk(rsp_data == e, "R3/R5", "read data", longint'(rsp_data), longint'(e));
      end
    end
  end

  task automatic do_store(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_t w;
    st_addr = a; st_data = d; st_valid = 1;
    do @(negedge clk); while (!st_ready);
    w.a = a; w.d = d;
    exp_wr.push_back(w);
    shadow[int'(a)] = d;
    @(posedge clk); #1 st_valid = 0;
  endtask

  task automatic do_read(logic [AW-1:0] a, logic wb, logic [AW-1:0] wa,
                         logic [DW-1:0] wd, output int acc_cyc);
    wr_t w;
    rd_addr = a; rd_wb_valid = wb; rd_wb_addr = wa; rd_wb_data = wd; rd_valid = 1;
    do @(negedge clk); while (!rd_ready);
    acc_cyc = cyc;
    exp_rsp.push_back(sh_val(int'(a)));
    if (wb) begin
      w.a = wa; w.d = wd;
      exp_wr.push_back(w);
      shadow[int'(wa)] = wd;
    end
    @(posedge clk); #1 rd_valid = 0; rd_wb_valid = 0;
    while (exp_rsp.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic wait_drained();
    while (exp_wr.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(empty == 1 && full == 0, "R7", "empty after drain", longint'({full, empty}), 1);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual running expected finished");
    finish_test();
  end

  initial begin
    int acc, cnt0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(empty == 1, "R7", "empty after reset", longint'(empty), 1);
    chk(full == 0, "R7", "full after reset", longint'(full), 0);
    chk(st_ready == 1, "R1", "st_ready after reset", longint'(st_ready), 1);
    chk(rd_ready == 1, "R8", "rd_ready after reset", longint'(rd_ready), 1);
    chk(mem_req_valid == 0, "R2", "no request after reset", longint'(mem_req_valid), 0);
    chk(rsp_valid == 0, "R3", "no response after reset", longint'(rsp_valid), 0);
    @(posedge clk); #1;

    // fill with parked stores, duplicate address 0x10 (R1, R7, R3)
    mem_rdy = 0;
    do_store(8'h10, 16'h1111);
    do_store(8'h20, 16'h2222);
    do_store(8'h10, 16'h3333);
    do_store(8'h30, 16'h4444);
    @(negedge clk);
    chk(full == 1, "R7", "full with DEPTH entries", longint'(full), 1);
    chk(st_ready == 0, "R1", "st_ready low when full", longint'(st_ready), 0);
    @(posedge clk); #1;
    cnt0 = rd_req_cnt;
    do_read(8'h10, 0, '0, '0, acc);   // youngest match 0x3333 (R3)
    chk(rsp_cyc == acc + 1, "R3", "hit latency", longint'(rsp_cyc - acc), 1);
    do_read(8'h20, 0, '0, '0, acc);
    do_read(8'h30, 0, '0, '0, acc);
    chk(rd_req_cnt == cnt0, "R3", "no memory read for hits", longint'(rd_req_cnt), longint'(cnt0));

    // miss while full and port stalled: read goes first (R4, R8, R5)
    op_log.delete();
    wr_during_read = 0;
    fork
      do_read(8'h40, 0, '0, '0, acc);
      begin
        repeat (3) @(negedge clk);
        chk(rd_ready == 0, "R8", "rd_ready low during miss", longint'(rd_ready), 0);
        chk(mem_req_valid && !mem_req_write && mem_req_addr == 8'h40, "R4",
            "read request presented", longint'({mem_req_valid, mem_req_write, mem_req_addr}),
            longint'({1'b1, 1'b0, 8'h40}));
        @(posedge clk); #1 mem_rdy = 1;
      end
    join
    chk(op_log.size() > 0 && op_log[0] == 1'b0, "R4", "first memory op is the read",
        longint'(op_log.size() > 0 ? op_log[0] : 1'b1), 0);
    chk(wr_during_read == 0, "R4", "writes during read", longint'(wr_during_read), 0);
    wait_drained();

    // store stalled by a full queue until an entry drains (R1)
    mem_rdy = 0;
    do_store(8'h50, 16'h5050);
    do_store(8'h51, 16'h5151);
    do_store(8'h52, 16'h5252);
    do_store(8'h53, 16'h5353);
    fork
      do_store(8'h58, 16'hAAAA);
      begin
        repeat (3) @(negedge clk);
        chk(st_ready == 0 && full == 1, "R1", "store held while full",
            longint'({st_ready, full}), longint'(2'b01));
        @(posedge clk); #1 mem_rdy = 1;
      end
    join
    wait_drained();

    // read miss with a dirty victim (R6)
    first_rd_req_cyc = -1;
    op_log.delete();
    do_read(8'h60, 1, 8'h70, 16'hBEEF, acc);
    chk(first_rd_req_cyc == acc + 1, "R6", "read request cycle after accept",
        longint'(first_rd_req_cyc - acc), 1);
    chk(op_log.size() > 0 && op_log[0] == 1'b0, "R6", "read before victim writeback",
        longint'(op_log.size() > 0 ? op_log[0] : 1'b1), 0);
    do_read(8'h70, 0, '0, '0, acc);
    wait_drained();

    // mixed stream with a toggling memory port (R2, R3, R5)
    for (int i = 0; i < 16; i++) begin
      mem_rdy = i[0];
      do_store(AW'((i * 5) % 12), DW'(16'h0C00 + i));
    end
    mem_rdy = 1;
    for (int i = 0; i < 12; i++)
      do_read(AW'(i), (i % 3 == 0), AW'(8'h80 + i), DW'(16'hD000 + i), acc);
    wait_drained();
    chk(exp_rsp.size() == 0, "R3", "all responses seen", longint'(exp_rsp.size()), 0);
    finish_test();
  end
endmodule